// File: doc/BRIEF.md
# Precise Trap Commit Unit

This block is the trap control for an in-order five-stage pipeline (fetch, decode, execute, memory, writeback). It carries a small control pipeline next to the datapath: each instruction's valid bit, program counter and exception flags move from stage to stage with it. Faults found early are not acted on where they appear. They ride along as flags, and only the memory stage, which is the commit point, may turn them into a trap. Traps are therefore precise: every older instruction has retired, and no younger one ever writes back.

When the memory-stage instruction traps, the block records a cause code and the faulting program counter. It asserts a kill for each of the fetch, decode, execute and memory stages, and it presents a fixed handler address as the fetch redirect target. An asynchronous interrupt line is latched and held pending until a valid instruction sits at the commit point. It is then taken on that instruction and takes precedence over any exception it carries. The datapath itself is not part of the block.

Top module: `trap_commit_unit`

## Requirements
- R1: While reset is high and after it is released, the cause register reads 0, the EPC register reads 0, and both the writeback valid and the redirect are low.
- R2: A fault flagged in fetch, decode or execute raises no redirect until its instruction is valid in the memory stage. An instruction fetched with valid in cycle c is in the memory stage in cycle c+3.
- R3: When one instruction has several faults, the one from the earliest stage sets the cause code. Fetch address fault is 1, illegal opcode is 2, overflow is 3 and data address fault is 4.
- R4: An interrupt present while the memory stage is valid traps that instruction with cause code 8, even if the instruction also has exceptions.
- R5: In the cycle after a trap, the cause register holds the trap's code and the EPC register holds the program counter of the instruction that trapped.
- R6: In the trap cycle, all four kill outputs and the redirect are high, and the redirect address equals the HANDLER_PC parameter.
- R7: Neither the trapping instruction nor any younger instruction reaches writeback. The writeback valid is low in the cycle after a trap.
- R8: A memory-stage instruction that does not trap retires: in the next cycle the writeback valid is high and the writeback PC equals that instruction's PC.
- R9: A fault in an older instruction traps before, and instead of, a fault in a younger instruction that follows it.
- R10: An interrupt pulse that arrives while the memory stage is empty stays pending. It is taken on the next valid memory-stage instruction and then cleared, so it causes exactly one trap.
- R11: Instructions killed by a trap have their flags cleared and never trap later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fe_valid_i | input | 1 | A valid instruction is in fetch |
| fe_pc_i | input | PC_W | PC of the fetch-stage instruction |
| fe_fault_i | input | 1 | Fetch address fault for the fetch-stage instruction |
| id_illegal_i | input | 1 | Illegal opcode for the decode-stage instruction |
| ex_ovf_i | input | 1 | Arithmetic overflow for the execute-stage instruction |
| mem_fault_i | input | 1 | Data address fault for the memory-stage instruction |
| irq_i | input | 1 | External interrupt request |
| kill_fe_o | output | 1 | Squash the fetch stage |
| kill_de_o | output | 1 | Squash the decode stage |
| kill_ex_o | output | 1 | Squash the execute stage |
| kill_mem_o | output | 1 | Squash the memory stage |
| redirect_o | output | 1 | Load the redirect address into fetch |
| redirect_pc_o | output | PC_W | Handler address |
| cause_o | output | 4 | Cause register |
| epc_o | output | PC_W | Exception PC register |
| wb_valid_o | output | 1 | An instruction retires this cycle |
| wb_pc_o | output | PC_W | PC of the retiring instruction |

## Verification
The assertions take for granted that the pipeline advances one stage on every clock, since the block has no stall input. They also take for granted that the stage fault inputs matter only while their stage holds a valid instruction, and that after a trap the datapath really does fetch from the handler address. The stimulus keeps to these assumptions. It sends each instruction through the stages on consecutive cycles and raises each fault input only in the cycle its instruction occupies that stage. It drives fetch with idle bubbles after a trap instead of modelling the handler stream, so the kill and no-late-trap checks see only the block's own state.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [3:0] {
        CAUSE_NONE    = 4'd0,
        CAUSE_IFETCH  = 4'd1,
        CAUSE_ILLEGAL = 4'd2,
        CAUSE_OVF     = 4'd3,
        CAUSE_DADDR   = 4'd4,
        CAUSE_IRQ     = 4'd8
    } cause_e;

    // exception flags carried with an instruction, earliest stage first
    typedef struct packed {
        logic ifetch;
        logic illegal;
        logic ovf;
        logic daddr;
    } exc_t;

    localparam int unsigned NUM_CARRY = 3;   // decode, execute, memory latches

    function automatic cause_e pick_cause(input exc_t f);
        if (f.ifetch)       return CAUSE_IFETCH;
        else if (f.illegal) return CAUSE_ILLEGAL;
        else if (f.ovf)     return CAUSE_OVF;
        else if (f.daddr)   return CAUSE_DADDR;
        else                return CAUSE_NONE;
    endfunction

endpackage

// File: rtl/trap_flag_pipe.sv
module trap_flag_pipe
    import trap_pkg::*;
#(
    parameter int unsigned PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fe_valid_i,
    input  logic [PC_W-1:0] fe_pc_i,
    input  logic            fe_fault_i,
    input  logic            id_illegal_i,
    input  logic            ex_ovf_i,
    input  logic            trap_i,
    output logic            m_valid_o,
    output logic [PC_W-1:0] m_pc_o,
    output exc_t            m_flags_o,
    output logic            wb_valid_o,
    output logic [PC_W-1:0] wb_pc_o
);
    localparam int unsigned LAST = NUM_CARRY - 1;

    logic            v_q  [NUM_CARRY];
    logic [PC_W-1:0] pc_q [NUM_CARRY];
    exc_t            fl_q [NUM_CARRY];
    logic            v_d  [NUM_CARRY];
    logic [PC_W-1:0] pc_d [NUM_CARRY];
    exc_t            fl_d [NUM_CARRY];

    always_comb begin
        for (int s = 0; s < NUM_CARRY; s++) begin
            if (s == 0) begin
                v_d[s]  = fe_valid_i;
                pc_d[s] = fe_pc_i;
                fl_d[s] = '0;
                fl_d[s].ifetch = fe_fault_i & fe_valid_i;
            end else begin
                v_d[s]  = v_q[s-1];
                pc_d[s] = pc_q[s-1];
                fl_d[s] = fl_q[s-1];
                if (s == 1) fl_d[s].illegal = fl_q[s-1].illegal | (id_illegal_i & v_q[s-1]);
                if (s == 2) fl_d[s].ovf     = fl_q[s-1].ovf     | (ex_ovf_i & v_q[s-1]);
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < NUM_CARRY; s++) begin
            if (rst || trap_i) begin
                v_q[s]  <= 1'b0;
                fl_q[s] <= '0;
                pc_q[s] <= '0;
            end else begin
                v_q[s]  <= v_d[s];
                fl_q[s] <= fl_d[s];
                pc_q[s] <= pc_d[s];
            end
        end
    end

    logic            w_v_q;
    logic [PC_W-1:0] w_pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            w_v_q  <= 1'b0;
            w_pc_q <= '0;
        end else begin
            w_v_q  <= v_q[LAST] & ~trap_i;
            w_pc_q <= pc_q[LAST];
        end
    end

    assign m_valid_o  = v_q[LAST];
    assign m_pc_o     = pc_q[LAST];
    assign m_flags_o  = fl_q[LAST];
    assign wb_valid_o = w_v_q;
    assign wb_pc_o    = w_pc_q;

    // R7
    no_late_wb_chk: assert property (@(posedge clk) disable iff (rst)
        trap_i |=> !wb_valid_o);

    // R11
    kill_clears_chk: assert property (@(posedge clk) disable iff (rst)
        trap_i |=> (!v_q[0] && !v_q[1] && !v_q[2] && fl_q[2] == '0));

    // R8
    retire_chk: assert property (@(posedge clk) disable iff (rst)
        (m_valid_o && !trap_i) |=> (wb_valid_o && wb_pc_o == $past(m_pc_o)));

endmodule

// File: rtl/trap_irq_hold.sv
module trap_irq_hold (
    input  logic clk,
    input  logic rst,
    input  logic irq_i,
    input  logic m_valid_i,
    output logic irq_req_o
);
    logic pend_q;

    assign irq_req_o = pend_q | irq_i;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= irq_req_o & ~m_valid_i;
    end

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_i && !m_valid_i) |=> irq_req_o);

    // R10
    irq_once_chk: assert property (@(posedge clk) disable iff (rst)
        (m_valid_i && !irq_i) |=> !pend_q);

endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   m_valid_i,
    input  exc_t   m_flags_i,
    input  logic   mem_fault_i,
    input  logic   irq_req_i,
    output logic   trap_o,
    output cause_e cause_o
);
    exc_t all_fl;

    always_comb begin
        all_fl       = m_flags_i;
        all_fl.daddr = m_flags_i.daddr | mem_fault_i;
        trap_o       = m_valid_i & (irq_req_i | (|all_fl));
        cause_o      = irq_req_i ? CAUSE_IRQ : pick_cause(all_fl);
    end

    // R4
    irq_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req_i && m_valid_i) |-> (trap_o && cause_o == CAUSE_IRQ));

    // R2
    commit_only_chk: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> m_valid_i);

    // R3
    early_stage_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_o && !irq_req_i && m_flags_i.ifetch) |-> cause_o == CAUSE_IFETCH);

endmodule

// File: rtl/trap_csr.sv
module trap_csr
    import trap_pkg::*;
#(
    parameter int unsigned PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trap_i,
    input  cause_e          cause_i,
    input  logic [PC_W-1:0] pc_i,
    output logic [3:0]      cause_o,
    output logic [PC_W-1:0] epc_o
);
    logic [3:0]      cause_q;
    logic [PC_W-1:0] epc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= 4'd0;
            epc_q   <= '0;
        end else if (trap_i) begin
            cause_q <= cause_i;
            epc_q   <= pc_i;
        end
    end

    assign cause_o = cause_q;
    assign epc_o   = epc_q;

    // R5
    record_chk: assert property (@(posedge clk) disable iff (rst)
        trap_i |=> (cause_o == $past(cause_i) && epc_o == $past(pc_i) && cause_o != 4'd0));

endmodule

// File: rtl/trap_commit_unit.sv
module trap_commit_unit
    import trap_pkg::*;
#(
    parameter int unsigned     PC_W       = 32,
    parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0180
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fe_valid_i,
    input  logic [PC_W-1:0] fe_pc_i,
    input  logic            fe_fault_i,
    input  logic            id_illegal_i,
    input  logic            ex_ovf_i,
    input  logic            mem_fault_i,
    input  logic            irq_i,
    output logic            kill_fe_o,
    output logic            kill_de_o,
    output logic            kill_ex_o,
    output logic            kill_mem_o,
    output logic            redirect_o,
    output logic [PC_W-1:0] redirect_pc_o,
    output logic [3:0]      cause_o,
    output logic [PC_W-1:0] epc_o,
    output logic            wb_valid_o,
    output logic [PC_W-1:0] wb_pc_o
);
    logic            trap;
    cause_e          cause_sel;
    logic            m_valid;
    logic [PC_W-1:0] m_pc;
    exc_t            m_flags;
    logic            irq_req;

    trap_flag_pipe #(.PC_W(PC_W)) u_pipe (
        .clk(clk), .rst(rst),
        .fe_valid_i(fe_valid_i), .fe_pc_i(fe_pc_i), .fe_fault_i(fe_fault_i),
        .id_illegal_i(id_illegal_i), .ex_ovf_i(ex_ovf_i), .trap_i(trap),
        .m_valid_o(m_valid), .m_pc_o(m_pc), .m_flags_o(m_flags),
        .wb_valid_o(wb_valid_o), .wb_pc_o(wb_pc_o)
    );

    trap_irq_hold u_irq (
        .clk(clk), .rst(rst), .irq_i(irq_i), .m_valid_i(m_valid),
        .irq_req_o(irq_req)
    );

    trap_arbiter u_arb (
        .clk(clk), .rst(rst), .m_valid_i(m_valid), .m_flags_i(m_flags),
        .mem_fault_i(mem_fault_i), .irq_req_i(irq_req),
        .trap_o(trap), .cause_o(cause_sel)
    );

    trap_csr #(.PC_W(PC_W)) u_csr (
        .clk(clk), .rst(rst), .trap_i(trap), .cause_i(cause_sel), .pc_i(m_pc),
        .cause_o(cause_o), .epc_o(epc_o)
    );

    assign kill_fe_o     = trap;
    assign kill_de_o     = trap;
    assign kill_ex_o     = trap;
    assign kill_mem_o    = trap;
    assign redirect_o    = trap;
    assign redirect_pc_o = HANDLER_PC;

    // R6
    kill_all_chk: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> (kill_fe_o && kill_de_o && kill_ex_o && kill_mem_o
                        && redirect_pc_o == HANDLER_PC));

endmodule

// File: tb/sim_trap_commit_unit.sv
`timescale 1ns/100ps
module sim_trap_commit_unit;
    localparam int unsigned PC_W    = 32;
    localparam logic [31:0] HANDLER = 32'h0000_0180;

    logic clk = 1'b0;
    logic rst;
    logic fe_valid, fe_fault, id_illegal, ex_ovf, mem_fault, irq;
    logic [31:0] fe_pc;
    logic kfe, kde, kex, kmem, redir, wbv;
    logic [31:0] redir_pc, epc, wbpc;
    logic [3:0] cause;

    always #2.5 clk = ~clk;

    trap_commit_unit #(.PC_W(PC_W), .HANDLER_PC(HANDLER)) u0 (
        .clk(clk), .rst(rst), .fe_valid_i(fe_valid), .fe_pc_i(fe_pc),
        .fe_fault_i(fe_fault), .id_illegal_i(id_illegal), .ex_ovf_i(ex_ovf),
        .mem_fault_i(mem_fault), .irq_i(irq),
        .kill_fe_o(kfe), .kill_de_o(kde), .kill_ex_o(kex), .kill_mem_o(kmem),
        .redirect_o(redir), .redirect_pc_o(redir_pc), .cause_o(cause),
        .epc_o(epc), .wb_valid_o(wbv), .wb_pc_o(wbpc)
    );

    int n_chk = 0;
    int n_bad = 0;

    // bits [8:4] = fetch fault, illegal, overflow, data fault, irq; [3:0] = expected cause
    localparam logic [8:0] VEC [10] = '{
        {5'b00000, 4'd0}, {5'b10000, 4'd1}, {5'b01000, 4'd2}, {5'b00100, 4'd3},
        {5'b00010, 4'd4}, {5'b11110, 4'd1}, {5'b01010, 4'd2}, {5'b00110, 4'd3},
        {5'b10001, 4'd8}, {5'b00011, 4'd8}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        fe_valid = 0; fe_fault = 0; id_illegal = 0; ex_ovf = 0; mem_fault = 0; irq = 0;
        fe_pc = '0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // one instruction alone in the pipe; returns redirect seen at commit
    task automatic run_one(input logic [31:0] pc, input logic [4:0] fl, output logic took);
        idle();
        fe_valid = 1; fe_pc = pc; fe_fault = fl[4];
        #1 chk(redir == 0, "R2 no redirect in fetch", {31'd0, redir}, 0);
        step();
        idle(); id_illegal = fl[3];
        #1 chk(redir == 0, "R2 no redirect in decode", {31'd0, redir}, 0);
        step();
        idle(); ex_ovf = fl[2];
        #1 chk(redir == 0, "R2 no redirect in execute", {31'd0, redir}, 0);
        step();
        idle(); mem_fault = fl[1]; irq = fl[0];
        #1 took = redir;
        step();
        idle();
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=expired expected=done");
        report();
    end

    initial begin
        logic took;
        idle();
        rst = 1;
        step(); step();
        chk(cause == 0 && epc == 0, "R1 reset regs", {cause, epc[27:0]}, 0);
        chk(wbv == 0 && redir == 0, "R1 reset outputs", {wbv, redir}, 0);
        rst = 0;
        step();
        chk(cause == 0 && wbv == 0 && redir == 0, "R1 after release", {28'd0, cause}, 0);

        // table walk: single instructions with fault mixes (R3, R4, R5, R7, R8)
        for (int k = 0; k < 10; k++) begin
            logic [31:0] pc;
            logic [3:0]  expc;
            logic [3:0]  prev;
            pc   = 32'h1000 + 32'(k) * 16;
            expc = VEC[k][3:0];
            prev = cause;
            run_one(pc, VEC[k][8:4], took);
            if (expc == 0) begin
                chk(took == 0, "R8 clean no trap", {31'd0, took}, 0);
                chk(wbv == 1 && wbpc == pc, "R8 clean retire", wbpc, pc);
                chk(cause == prev, "R8 cause untouched", {28'd0, cause}, {28'd0, prev});
            end else begin
                chk(took == 1, "R6 trap redirect", {31'd0, took}, 1);
                chk(cause == expc, "R3 R4 cause code", {28'd0, cause}, {28'd0, expc});
                chk(epc == pc, "R5 epc", epc, pc);
                chk(wbv == 0, "R7 no writeback", {31'd0, wbv}, 0);
            end
        end

        // R6: kills and handler address in the trap cycle
        idle(); fe_valid = 1; fe_pc = 32'h2000; step();
        idle(); id_illegal = 1; step();
        idle(); step();
        idle();
        #1 chk(kfe && kde && kex && kmem && redir, "R6 all kills", {27'd0, kfe, kde, kex, kmem, redir}, 32'h1f);
        chk(redir_pc == HANDLER, "R6 handler pc", redir_pc, HANDLER);
        step();

        // R9 + R11: older overflow, younger fetch fault right behind
        idle(); fe_valid = 1; fe_pc = 32'h3000; step();
        idle(); fe_valid = 1; fe_pc = 32'h3004; fe_fault = 1; step();
        idle(); ex_ovf = 1; step();
        idle();
        #1 chk(redir == 1, "R9 older traps", {31'd0, redir}, 1);
        step();
        chk(cause == 3 && epc == 32'h3000, "R9 older cause/epc", epc, 32'h3000);
        for (int j = 0; j < 4; j++) begin
            #1 chk(redir == 0, "R11 killed never traps", {31'd0, redir}, 0);
            step();
        end
        chk(cause == 3 && wbv == 0, "R11 cause kept", {28'd0, cause}, 3);

        // R8 + R7: older clean retires, younger illegal traps
        idle(); fe_valid = 1; fe_pc = 32'h4000; step();
        idle(); fe_valid = 1; fe_pc = 32'h4004; step();
        idle(); id_illegal = 1; step();
        idle(); step();
        chk(wbv == 1 && wbpc == 32'h4000, "R8 older retires", wbpc, 32'h4000);
        #1 chk(redir == 1, "R7 younger traps", {31'd0, redir}, 1);
        step();
        chk(cause == 2 && epc == 32'h4004, "R5 younger epc", epc, 32'h4004);
        chk(wbv == 0, "R7 trapper no writeback", {31'd0, wbv}, 0);

        // R10: interrupt while memory stage empty waits, then taken once
        idle(); step();
        irq = 1; step();
        idle();
        #1 chk(redir == 0, "R10 waits while empty", {31'd0, redir}, 0);
        step();
        run_one(32'h5000, 5'b00000, took);
        chk(took == 1, "R10 pending taken", {31'd0, took}, 1);
        chk(cause == 8 && epc == 32'h5000, "R10 irq cause/epc", epc, 32'h5000);
        run_one(32'h5010, 5'b00000, took);
        chk(took == 0 && wbv == 1, "R10 taken only once", {31'd0, took}, 0);

        report();
    end
endmodule